// File: doc/BRIEF.md
# Serial Peripheral Master with Character FIFOs

This block is a full-duplex serial peripheral master. Each character is between 1 and 16 bits long, and the length can be changed. The block sends a character on the data-out line and, over the same clock edges, receives one on the data-in line. The most significant bit goes first. The register side sees two small FIFOs through a push/pop port: a transmit queue and a receive queue. The serial clock comes from the system clock through a divider that software sets.

While the block is enabled and the transmit queue holds data, the block pulls the head entry into its shift register and starts a transfer. No software action is needed. The select line stays low, and the characters run back to back until the queue is empty. Each finished character goes into the receive queue, right-aligned. If the receive queue is full when a character finishes, that character is lost and a sticky overrun flag is raised. Clearing the enable stops the link at once, releases the data-out line and clears the flag.

Top module: `spi_master_fifo`

## Requirements
- R1: After reset, the select line is high, the serial clock is low, the receive queue is empty, the transmit queue is not full and the overrun flag is low.
- R2: A character is len_i+1 bits long (len_i = 0 gives 1 bit, 15 gives 16 bits). The low len_i+1 bits of the pushed word go out on mosi_o, most significant of those bits first.
- R3: The bits sampled on miso_i are delivered on rx_data_o right-aligned, first bit as the most significant of the len_i+1 bits, and all higher bits zero.
- R4: The serial clock idles low. While a transfer runs it has a period of 2*(div_i+1) system clocks. mosi_o changes only on falling edges of the serial clock, and miso_i is sampled on rising edges.
- R5: While the transmit queue holds data, characters follow one another with the select line held low throughout. The select line rises only when the queue is empty after a character.
- R6: Both queues hold 4 words of 16 bits. A push into a full transmit queue is ignored, and so is a pop from an empty receive queue. tx_full_o and rx_empty_o report the fill state.
- R7: A character that finishes while the receive queue is full is dropped, and ovr_o goes high. ovr_o stays high until en_i is low for a clock edge.
- R8: While en_i is low, no transfer takes place, mosi_oe_o is low, the select line is high and the serial clock is low. Words may still be pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| len_i | input | 4 | Character length minus one |
| div_i | input | 8 | Clock divider N; serial clock = clk/(2*(N+1)) |
| tx_data_i | input | 16 | Word to push into the transmit queue |
| tx_push_i | input | 1 | Push strobe |
| tx_full_o | output | 1 | Transmit queue full |
| rx_data_o | output | 16 | Head of the receive queue |
| rx_pop_i | input | 1 | Pop strobe |
| rx_empty_o | output | 1 | Receive queue empty |
| ovr_o | output | 1 | Sticky receive overrun |
| sck_o | output | 1 | Serial clock |
| ss_no | output | 1 | Slave select, active low |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | Serial data in |

## Verification
The bench uses the default parameters: 16-bit words, 4-deep queues and an 8-bit divider. Because of this, every character length from 1 to 16 bits can be swept against divider values 0 to 2, with two data patterns for each. A behavioural slave answers with patterns of its own. Every burst fills the transmit queue past its depth, so the ignored push, the full-queue back-to-back run and a full drain of the receive queue happen on every pass. A short extra burst overfills the receive queue to reach the overrun path and the clearing of the flag.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic {ST_IDLE, ST_XFER} spi_state_e;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4   // power of two
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [AW:0]      cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[i] <= '0;
      else if (do_push && wr_q == AW'(i))         mem_q[i] <= data_i;
    end
  end
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              tick_i,
  input  logic              tx_empty_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              miso_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              run_o,
  output logic              sck_o,
  output logic              ss_no,
  output logic              mosi_o
);
  localparam logic [LEN_W-1:0] SH_MAX = LEN_W'(DATA_W - 1);

  spi_state_e        state_q;
  logic              sck_q, ss_q;
  logic [DATA_W-1:0] sh_q, rx_q;
  logic [LEN_W-1:0]  bits_q;
  logic              last, take;
  logic [DATA_W-1:0] ld_val;

  // left-align so the first bit sits at the top of the shifter
  assign ld_val    = tx_data_i << (SH_MAX - len_i);
  assign last      = (state_q == ST_XFER) && tick_i && sck_q && (bits_q == '0);
  assign take      = en_i && !tx_empty_i && ((state_q == ST_IDLE) || last);
  assign tx_pop_o  = take;
  assign rx_push_o = en_i && last;
  assign rx_data_o = rx_q;
  assign run_o     = (state_q == ST_XFER);
  assign sck_o     = sck_q;
  assign ss_no     = ss_q;
  assign mosi_o    = sh_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      ss_q    <= 1'b1;
      sh_q    <= '0;
      rx_q    <= '0;
      bits_q  <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      ss_q    <= 1'b1;
    end else if (take) begin
      state_q <= ST_XFER;
      sck_q   <= 1'b0;
      ss_q    <= 1'b0;
      sh_q    <= ld_val;
      rx_q    <= '0;
      bits_q  <= len_i;
    end else if (last) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      ss_q    <= 1'b1;
    end else if (state_q == ST_XFER && tick_i) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_q  <= {rx_q[DATA_W-2:0], miso_i};
      end else begin
        sck_q  <= 1'b0;
        sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
        bits_q <= bits_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_master_fifo.sv
module spi_master_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_push_i,
  output logic              tx_full_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              rx_pop_i,
  output logic              rx_empty_o,
  output logic              ovr_o,
  output logic              sck_o,
  output logic              ss_no,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i
);
  logic              tx_empty, tx_pop, rx_push, rx_full, run, tick;
  logic [DATA_W-1:0] tx_head, rx_word;
  logic              ovr_q;

  spi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i(tx_push_i), .data_i(tx_data_i),
    .pop_i(tx_pop), .data_o(tx_head),
    .full_o(tx_full_o), .empty_o(tx_empty)
  );

  spi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i(rx_push), .data_i(rx_word),
    .pop_i(rx_pop_i), .data_o(rx_data_o),
    .full_o(rx_full), .empty_o(rx_empty_o)
  );

  spi_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i, .rst_ni, .run_i(run), .div_i, .tick_o(tick)
  );

  spi_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_eng (
    .clk_i, .rst_ni, .en_i, .len_i,
    .tick_i(tick), .tx_empty_i(tx_empty), .tx_data_i(tx_head), .miso_i,
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_word),
    .run_o(run), .sck_o, .ss_no, .mosi_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovr_q <= 1'b0;
    else if (!en_i)             ovr_q <= 1'b0;
    else if (rx_push && rx_full) ovr_q <= 1'b1;
  end

  assign ovr_o     = ovr_q;
  assign mosi_oe_o = en_i;
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sck_o,
  input logic ss_no,
  input logic mosi_o,
  input logic ovr_o
);
  always @(negedge clk_i)
    if (!rst_ni) assert_reset_state_R1: assert (ss_no && !sck_o && !ovr_o);

  assert_disable_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ss_no && !sck_o));

  assert_sck_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> !sck_o);

  assert_mosi_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $stable(mosi_o));

  assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ovr_o) && $past(en_i)) |-> ovr_o);

  assert_ovr_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ovr_o);
endmodule

bind spi_master_fifo spi_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sck_o(sck_o),
  .ss_no(ss_no), .mosi_o(mosi_o), .ovr_o(ovr_o)
);

// File: tb/spi_master_fifo_test.sv
`timescale 1ns/1ps
module spi_master_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  len = '0;
  logic [7:0]  div = '0;
  logic [15:0] tx_data = '0;
  logic        tx_push = 1'b0, rx_pop = 1'b0;
  logic        miso = 1'b0;
  logic        tx_full, rx_empty, ovr, sck, ss_n, mosi, mosi_oe;
  logic [15:0] rx_data;

  int checks = 0, errors = 0;
  int bits = 1;
  logic [15:0] mtx [8];
  logic [15:0] spat [8];
  logic [15:0] got [8];
  int sidx = 0, scnt = 0;
  bit reload = 0;
  logic [15:0] sl_tx = '0, sl_rx = '0;
  longint cyc = 0, last_rise = 0;
  bit have_last = 0, sck_prev = 0;
  int per_bad = 0, ss_falls = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_master_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .len_i(len), .div_i(div),
    .tx_data_i(tx_data), .tx_push_i(tx_push), .tx_full_o(tx_full),
    .rx_data_o(rx_data), .rx_pop_i(rx_pop), .rx_empty_o(rx_empty),
    .ovr_o(ovr), .sck_o(sck), .ss_no(ss_n), .mosi_o(mosi),
    .mosi_oe_o(mosi_oe), .miso_i(miso)
  );

  // behavioural slave, mode 0
  always @(negedge ss_n) begin
    scnt = 0; reload = 0; sl_rx = '0;
    sl_tx = spat[sidx & 7] << (16 - bits);
    miso = sl_tx[15];
    ss_falls++;
  end
  always @(posedge sck) begin
    sl_rx = {sl_rx[14:0], mosi};
    scnt++;
    if (scnt == bits) begin
      got[sidx & 7] = sl_rx;
      sidx++; scnt = 0; sl_rx = '0; reload = 1;
    end
  end
  always @(negedge sck) begin
    if (reload) begin
      reload = 0;
      sl_tx = spat[sidx & 7] << (16 - bits);
    end else sl_tx = sl_tx << 1;
    miso = sl_tx[15];
  end

  // serial clock period monitor (R4)
  always @(negedge clk) begin
    cyc++;
    if (ss_n) have_last = 0;
    else if (sck && !sck_prev) begin
      if (have_last && (cyc - last_rise) != 2 * (int'(div) + 1)) per_bad++;
      last_rise = cyc; have_last = 1;
    end
    sck_prev = sck;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(logic [15:0] d);
    @(negedge clk); tx_data = d; tx_push = 1'b1;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic pop_check(string req, logic [15:0] exp);
    @(negedge clk);
    check(req, {16'h0, rx_data}, {16'h0, exp});
    rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic wait_ss(logic lvl);
    int n = 0;
    while (ss_n !== lvl && n < 40000) begin @(negedge clk); n++; end
    if (n >= 40000) check("R5 timeout", {31'h0, ss_n}, {31'h0, lvl});
  endtask

  function automatic logic [15:0] mask_of(int b);
    return 16'((32'h1 << b) - 1);
  endfunction

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {27'h0, ss_n, sck, rx_empty, tx_full, ovr}, {27'h0, 5'b10100});
    rst_n = 1'b1;
    @(negedge clk);
    // pop on empty ignored
    rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    check("R6 pop empty", {31'h0, rx_empty}, 32'h1);

    for (int d = 0; d < 3; d++) begin
      for (int l = 0; l < 16; l++) begin
        for (int p = 0; p < 2; p++) begin
          logic [15:0] m;
          en = 1'b0; len = 4'(l); div = 8'(d); bits = l + 1;
          m = mask_of(bits);
          for (int c = 0; c < 5; c++) begin
            mtx[c]  = 16'(16'hB38E ^ (c * 16'h2F1D) ^ (p * 16'hFFFF) ^ (l << 9));
            spat[c] = 16'((16'h6C51 + c * 16'h1D3B) ^ (p * 16'h5A5A) ^ d);
          end
          sidx = 0;
          for (int c = 0; c < 5; c++) push(mtx[c]);  // fifth is ignored
          repeat (4) @(negedge clk);
          if (d == 0 && l == 0 && p == 0) begin
            check("R8 disabled idle", {29'h0, ss_n, sck, mosi_oe}, {29'h0, 3'b100});
            check("R6 tx full", {31'h0, tx_full}, 32'h1);
          end
          ss_falls = 0; per_bad = 0;
          @(negedge clk); en = 1'b1;
          wait_ss(1'b0);
          wait_ss(1'b1);
          repeat (3 * (d + 1) + 4) @(negedge clk);
          check("R5 single select", ss_falls, 1);
          check("R6 full push ignored", sidx, 4);
          check("R4 sck period", per_bad, 0);
          for (int c = 0; c < 4; c++) begin
            check("R2 mosi bits", {16'h0, got[c]}, {16'h0, mtx[c] & m});
            pop_check("R3 rx aligned", spat[c] & m);
          end
          check("R6 rx drained", {31'h0, rx_empty}, 32'h1);
        end
      end
    end

    // overrun: five characters into a four-entry receive queue
    en = 1'b0; len = 4'd3; div = '0; bits = 4;
    for (int c = 0; c < 5; c++) begin
      mtx[c] = 16'(c * 16'h0111 + 16'h0003);
      spat[c] = 16'(16'h0009 + c * 3);
    end
    sidx = 0;
    for (int c = 0; c < 4; c++) push(mtx[c]);
    @(negedge clk); en = 1'b1;
    wait_ss(1'b0); wait_ss(1'b1);
    @(negedge clk);
    check("R7 no overrun yet", {31'h0, ovr}, 32'h0);
    push(mtx[4]);
    wait_ss(1'b0); wait_ss(1'b1);
    repeat (3) @(negedge clk);
    check("R7 overrun set", {31'h0, ovr}, 32'h1);
    check("R2 fifth sent", {16'h0, got[4]}, {16'h0, mtx[4] & 16'hF});
    for (int c = 0; c < 4; c++) pop_check("R7 dropped keeps first four", spat[c] & 16'hF);
    check("R7 rx empty after drop", {31'h0, rx_empty}, 32'h1);
    check("R7 still sticky", {31'h0, ovr}, 32'h1);
    en = 1'b0;
    @(negedge clk);
    check("R7 cleared by disable", {31'h0, ovr}, 32'h0);
    check("R8 oe low", {31'h0, mosi_oe}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule